// File: doc/BRIEF.md
# Split-Transaction MSI Line Controller

This block tracks the coherence state of one cache line behind a bus on which every request must win arbitration before it goes out. A processor load or store that cannot be satisfied locally raises a bus request and parks the line in a waiting state. Three waiting states exist: one for a read miss, one for a write miss and one for an upgrade from a shared copy. The line sits there until the arbiter grants the bus. The controller then issues the bus command that matches the waiting state and settles into the final stable state.

While it waits, the controller keeps watching the snoop input. It resolves races with other caches' transactions. The main case is a shared copy that is awaiting an upgrade and loses its data to another cache's exclusive request. That line must fall back to a full write miss. Data movement, the arbiter and memory are outside the block.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid (code 0), the bus request is low, the bus command is none (2'b00), the writeback flag is low and the stall output is low.
- R2: A read (cpu_valid=1, cpu_write=0) to an Invalid line stalls at once, raises the bus request and moves to IS (code 3) on the next edge. In the cycle after the grant, the bus command is a read (2'b01) and the state is Shared (code 1).
- R3: A write to an Invalid line raises the bus request and moves to IM (code 4). In the cycle after the grant, the bus command is read-exclusive (2'b10) and the state is Modified (code 2).
- R4: A write to a Shared line raises the bus request and moves to SM (code 5). In the cycle after the grant, the bus command is invalidate (2'b11) and the state is Modified.
- R5: A read to Shared or Modified, or a write to Modified, does not stall, raises no bus request, issues no bus command and leaves the state unchanged.
- R6: A Modified line that snoops a read (snoop_cmd 2'b01) becomes Shared. One that snoops a read-exclusive (2'b10) becomes Invalid. In both cases the writeback flag is high for exactly the following cycle.
- R7: A Shared line that snoops a read-exclusive or an invalidate (2'b11) becomes Invalid with no writeback. A snooped read leaves it Shared.
- R8: A line in SM that snoops a read-exclusive or an invalidate before its grant moves to IM, and on its grant issues read-exclusive instead of invalidate. A snoop that arrives in the same cycle as the grant is ordered first.
- R9: Snoops seen in IS or IM leave the state unchanged and produce no writeback. The later grant still completes normally.
- R10: The stall output is high in every cycle the line is in a waiting state. It is low in the cycle the final stable state first appears, unless a new request needs the bus.
- R11: The bus request falls in the cycle after the grant is sampled. The bus command is non-none for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_stall | output | 1 | Processor must hold its access |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_cmd | output | 2 | Issued command: 00 none, 01 read, 10 read-exclusive, 11 invalidate |
| snoop_valid | input | 1 | Another cache's transaction observed |
| snoop_cmd | input | 2 | Observed command, same encoding as bus_cmd |
| snoop_wb | output | 1 | Line written back in response to a snoop |
| line_state | output | 3 | 0 I, 1 S, 2 M, 3 IS, 4 IM, 5 SM |

## Verification
The bench targets the upgrade race. A read-exclusive snooped while an upgrade waits must turn the later command into a read-exclusive. A design that ignored the snoop would issue an invalidate and claim Modified over data it no longer has. The same race is repeated with the snoop landing in the grant cycle. The bench also sends conflicting snoops to lines still waiting on a miss, where a design that reacted would lose its pending request or raise a spurious writeback. Finally, it watches the handshake edges: a request held a cycle too long, a command that lingers, or a stall released a cycle early or late is caught at the exact cycle.

// File: rtl/snoop_line_pkg.sv
package snoop_line_pkg;
    localparam int STATE_W = 3;
    localparam int CMD_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_I  = 3'd0,
        ST_S  = 3'd1,
        ST_M  = 3'd2,
        ST_IS = 3'd3,
        ST_IM = 3'd4,
        ST_SM = 3'd5
    } line_st_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_READX = 2'b10,
        CMD_INV   = 2'b11
    } bus_cmd_e;

    typedef struct packed {
        line_st_e state;
        logic     bus_req;
        bus_cmd_e bus_cmd;
        logic     wb;
    } ctrl_regs_t;

    function automatic logic is_waiting(line_st_e s);
        return (s == ST_IS) || (s == ST_IM) || (s == ST_SM);
    endfunction
endpackage

// File: rtl/snoop_line_next.sv
module snoop_line_next
    import snoop_line_pkg::*;
(
    input  ctrl_regs_t cur,
    input  logic       cpu_valid,
    input  logic       cpu_write,
    input  logic       bus_gnt,
    input  logic       snoop_valid,
    input  bus_cmd_e   snoop_cmd,
    output ctrl_regs_t nxt,
    output logic       stall
);
    logic snoop_kill;
    logic needs_bus;
    logic granted;

    always_comb begin
        snoop_kill = snoop_valid && (snoop_cmd == CMD_READX || snoop_cmd == CMD_INV);
        granted    = bus_gnt && cur.bus_req;
        needs_bus  = (cur.state == ST_I) || (cur.state == ST_S && cpu_write);
        stall      = is_waiting(cur.state) || (cpu_valid && (snoop_valid || needs_bus));

        nxt         = cur;
        nxt.bus_cmd = CMD_NONE;
        nxt.wb      = 1'b0;

        unique case (cur.state)
            ST_I: begin
                if (!snoop_valid && cpu_valid) begin
                    nxt.state   = cpu_write ? ST_IM : ST_IS;
                    nxt.bus_req = 1'b1;
                end
            end
            ST_S: begin
                if (snoop_valid) begin
                    if (snoop_kill) nxt.state = ST_I;
                end else if (cpu_valid && cpu_write) begin
                    nxt.state   = ST_SM;
                    nxt.bus_req = 1'b1;
                end
            end
            ST_M: begin
                if (snoop_valid && snoop_cmd == CMD_READ) begin
                    nxt.state = ST_S;
                    nxt.wb    = 1'b1;
                end else if (snoop_kill) begin
                    nxt.state = ST_I;
                    nxt.wb    = 1'b1;
                end
            end
            ST_IS: begin
                if (granted) begin
                    nxt.state   = ST_S;
                    nxt.bus_cmd = CMD_READ;
                    nxt.bus_req = 1'b0;
                end
            end
            ST_IM: begin
                if (granted) begin
                    nxt.state   = ST_M;
                    nxt.bus_cmd = CMD_READX;
                    nxt.bus_req = 1'b0;
                end
            end
            ST_SM: begin
                if (granted) begin
                    nxt.state   = ST_M;
                    nxt.bus_cmd = snoop_kill ? CMD_READX : CMD_INV;
                    nxt.bus_req = 1'b0;
                end else if (snoop_kill) begin
                    nxt.state = ST_IM;
                end
            end
            default: begin
                nxt.state   = ST_I;
                nxt.bus_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
    import snoop_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_valid,
    input  logic       cpu_write,
    output logic       cpu_stall,
    output logic       bus_req,
    input  logic       bus_gnt,
    output logic [1:0] bus_cmd,
    input  logic       snoop_valid,
    input  logic [1:0] snoop_cmd,
    output logic       snoop_wb,
    output logic [2:0] line_state
);
    localparam ctrl_regs_t RESET_VAL = '{state: ST_I, bus_req: 1'b0, bus_cmd: CMD_NONE, wb: 1'b0};

    ctrl_regs_t regs_d, regs_q;

    snoop_line_next u_next (
        .cur         (regs_q),
        .cpu_valid   (cpu_valid),
        .cpu_write   (cpu_write),
        .bus_gnt     (bus_gnt),
        .snoop_valid (snoop_valid),
        .snoop_cmd   (bus_cmd_e'(snoop_cmd)),
        .nxt         (regs_d),
        .stall       (cpu_stall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= RESET_VAL;
        else        regs_q <= regs_d;
    end

    assign bus_req    = regs_q.bus_req;
    assign bus_cmd    = regs_q.bus_cmd;
    assign snoop_wb   = regs_q.wb;
    assign line_state = regs_q.state;
endmodule

// File: rtl/snoop_line_chk.sv
module snoop_line_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_stall,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd,
    input logic       snoop_wb,
    input logic [2:0] line_state
);
    logic waiting;
    assign waiting = (line_state == 3'd3) || (line_state == 3'd4) || (line_state == 3'd5);

    a_r11_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !bus_req);

    a_r11_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'b00) |-> $past(bus_req && bus_gnt));

    a_r10_stall_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> cpu_stall);

    a_r6_wb_from_m: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_wb |-> ($past(line_state) == 3'd2));

    a_r9_is_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd3 && !bus_gnt) |=> (line_state == 3'd3));

    a_r2_req_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> waiting);
endmodule

bind snoop_line_ctrl snoop_line_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_stall  (cpu_stall),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .snoop_wb   (snoop_wb),
    .line_state (line_state)
);

// File: tb/tb_snoop_line_ctrl.sv
module tb_snoop_line_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0, cpu_write = 1'b0, bus_gnt = 1'b0, snoop_valid = 1'b0;
    logic [1:0] snoop_cmd = 2'b00;
    logic       cpu_stall, bus_req, snoop_wb;
    logic [1:0] bus_cmd;
    logic [2:0] line_state;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    localparam logic [2:0] S_I = 0, S_S = 1, S_M = 2, S_IS = 3, S_IM = 4, S_SM = 5;
    localparam logic [1:0] C_NONE = 0, C_RD = 1, C_RDX = 2, C_INV = 3;

    always #5 clk = ~clk;

    snoop_line_ctrl dut (.*);

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic idle_in();
        cpu_valid = 0; cpu_write = 0; bus_gnt = 0; snoop_valid = 0; snoop_cmd = C_NONE;
    endtask

    task automatic do_reset();
        idle_in(); rst_n = 0; cyc(); cyc(); rst_n = 1;
    endtask

    // Issue a miss/upgrade, wait, grant; leaves line in final stable state.
    task automatic fetch(input logic wr, input logic [2:0] wait_st, input logic [1:0] cmd,
                         input logic [2:0] fin, input string tag);
        cpu_valid = 1; cpu_write = wr; #1;
        chk(cpu_stall, 1, {tag, " stall on request"});
        cyc(); cpu_valid = 0; #1;
        chk(line_state, wait_st, {tag, " waiting state"});
        chk(bus_req, 1, {tag, " request raised"});
        chk(cpu_stall, 1, {tag, " R10 stall while waiting"});
        cyc();
        chk(line_state, wait_st, {tag, " holds without grant"});
        bus_gnt = 1; cyc(); bus_gnt = 0; #1;
        chk(bus_cmd, cmd, {tag, " command after grant"});
        chk(line_state, fin, {tag, " final state"});
        chk(bus_req, 0, {tag, " R11 request dropped"});
        chk(cpu_stall, 0, {tag, " R10 stall released"});
        cyc();
        chk(bus_cmd, C_NONE, {tag, " R11 command one cycle"});
    endtask

    task automatic snoop(input logic [1:0] c);
        snoop_valid = 1; snoop_cmd = c; cyc(); snoop_valid = 0; snoop_cmd = C_NONE;
    endtask

    task automatic t_reset();
        do_reset(); #1;
        chk(line_state, S_I, "R1 state");
        chk(bus_req, 0, "R1 req");
        chk(bus_cmd, C_NONE, "R1 cmd");
        chk(snoop_wb, 0, "R1 wb");
        chk(cpu_stall, 0, "R1 stall");
    endtask

    task automatic t_misses();
        do_reset(); fetch(0, S_IS, C_RD, S_S, "R2 read miss");
        do_reset(); fetch(1, S_IM, C_RDX, S_M, "R3 write miss");
        do_reset(); fetch(0, S_IS, C_RD, S_S, "R4 prep");
        fetch(1, S_SM, C_INV, S_M, "R4 upgrade");
    endtask

    task automatic t_hits();
        do_reset(); fetch(0, S_IS, C_RD, S_S, "R5 prep");
        cpu_valid = 1; cpu_write = 0; #1;
        chk(cpu_stall, 0, "R5 read hit S no stall");
        cyc(); chk(line_state, S_S, "R5 read hit S state");
        chk(bus_req, 0, "R5 read hit S no req");
        cpu_valid = 0;
        fetch(1, S_SM, C_INV, S_M, "R5 prep2");
        cpu_valid = 1; cpu_write = 1; #1;
        chk(cpu_stall, 0, "R5 write hit M no stall");
        cyc(); cpu_write = 0;
        chk(line_state, S_M, "R5 write hit M state");
        chk(bus_cmd, C_NONE, "R5 write hit M no cmd");
        cyc(); chk(line_state, S_M, "R5 read hit M state");
        chk(bus_req, 0, "R5 read hit M no req");
        cpu_valid = 0;
    endtask

    task automatic t_m_snoops();
        do_reset(); fetch(1, S_IM, C_RDX, S_M, "R6 prep");
        snoop(C_RD); #1;
        chk(line_state, S_S, "R6 M snoop read state");
        chk(snoop_wb, 1, "R6 M snoop read wb");
        cyc(); chk(snoop_wb, 0, "R6 wb one cycle");
        do_reset(); fetch(1, S_IM, C_RDX, S_M, "R6 prep2");
        snoop(C_RDX); #1;
        chk(line_state, S_I, "R6 M snoop readx state");
        chk(snoop_wb, 1, "R6 M snoop readx wb");
    endtask

    task automatic t_s_snoops();
        do_reset(); fetch(0, S_IS, C_RD, S_S, "R7 prep");
        snoop(C_RD); #1;
        chk(line_state, S_S, "R7 S snoop read");
        snoop(C_INV); #1;
        chk(line_state, S_I, "R7 S snoop inv");
        chk(snoop_wb, 0, "R7 no wb");
        do_reset(); fetch(0, S_IS, C_RD, S_S, "R7 prep2");
        snoop(C_RDX); #1;
        chk(line_state, S_I, "R7 S snoop readx");
    endtask

    task automatic t_sm_race();
        do_reset(); fetch(0, S_IS, C_RD, S_S, "R8 prep");
        cpu_valid = 1; cpu_write = 1; cyc(); cpu_valid = 0;
        chk(line_state, S_SM, "R8 in SM");
        snoop(C_RDX); #1;
        chk(line_state, S_IM, "R8 SM to IM");
        chk(bus_req, 1, "R8 request kept");
        bus_gnt = 1; cyc(); bus_gnt = 0;
        chk(bus_cmd, C_RDX, "R8 readx after race");
        chk(line_state, S_M, "R8 final M");
        // same-cycle snoop and grant
        do_reset(); fetch(0, S_IS, C_RD, S_S, "R8 prep2");
        cpu_valid = 1; cpu_write = 1; cyc(); cpu_valid = 0;
        snoop_valid = 1; snoop_cmd = C_INV; bus_gnt = 1; cyc(); idle_in();
        chk(bus_cmd, C_RDX, "R8 same-cycle race cmd");
        chk(line_state, S_M, "R8 same-cycle race state");
    endtask

    task automatic t_is_im_snoops();
        do_reset();
        cpu_valid = 1; cpu_write = 0; cyc(); cpu_valid = 0;
        snoop(C_RDX); #1;
        chk(line_state, S_IS, "R9 IS snoop readx");
        chk(snoop_wb, 0, "R9 IS no wb");
        bus_gnt = 1; cyc(); bus_gnt = 0;
        chk(bus_cmd, C_RD, "R9 IS grant cmd");
        chk(line_state, S_S, "R9 IS final");
        do_reset();
        cpu_valid = 1; cpu_write = 1; cyc(); cpu_valid = 0;
        snoop(C_RD); #1;
        chk(line_state, S_IM, "R9 IM snoop read");
        snoop(C_INV); #1;
        chk(line_state, S_IM, "R9 IM snoop inv");
        chk(snoop_wb, 0, "R9 IM no wb");
        bus_gnt = 1; cyc(); bus_gnt = 0;
        chk(bus_cmd, C_RDX, "R9 IM grant cmd");
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            finish_up();
        end
    end

    initial begin
        t_reset();
        t_misses();
        t_hits();
        t_m_snoops();
        t_s_snoops();
        t_sm_race();
        t_is_im_snoops();
        finish_up();
    end
endmodule